// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt sources and raises a single request line to a processor core. Each source carries a 3-bit priority (0 lowest, 7 highest), a trigger type and a software-written vector. Software enables, disables and clears sources through write-one command registers.

Software services an interrupt by reading the vector-read register. That read returns the vector of the winning source and pushes the winner's priority onto an internal nesting stack. While the level is on the stack, only strictly higher priorities can raise the request again. A write to the end-of-interrupt register removes one level from the stack. When no source qualifies, the read returns a programmable spurious vector.

Register access uses a single-cycle port with valid, write and address. Read data is registered and appears on the cycle after the access.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset every source is disabled, the nesting stack is empty, `irq_out` is low, and every mode, vector and spurious register reads zero.
- R2: Register map, by byte address: mode of source n at 0x00+n, vector of source n at 0x40+n, vector-read at 0x80, spurious vector at 0x81, enable command at 0x82, disable command at 0x83, clear command at 0x84, end-of-interrupt at 0x85. Writing a 1 to bit n of the enable or disable command enables or disables source n. Zero bits change nothing.
- R3: Mode register layout: priority in bits [2:0]; trigger in bits [5:4], where 00 is high level, 01 is rising edge, 10 is low level and 11 is falling edge. Other bits read zero. The vector registers and the spurious register read back what was written.
- R4: Only source 0 and sources 25 to 31 accept a trigger change. On sources 1 to 24 the trigger field ignores writes and stays at high level.
- R5: A source with a level trigger is pending while its input is at the active level, and it stops being pending as soon as the input leaves that level.
- R6: A source with an edge trigger latches pending on the selected input edge. The latch is cleared by a clear-command write with bit n set, or by a vector read that selects that source.
- R7: A vector read returns the vector of the enabled pending source with the highest priority. Among equal priorities, the lowest source number wins.
- R8: `irq_out` is high exactly when an enabled pending source has a priority strictly greater than the level on top of the stack. When the stack is empty, any enabled pending source qualifies.
- R9: A vector read while `irq_out` is low returns the spurious vector and leaves the stack unchanged.
- R10: A vector read that selects a source pushes that source's priority, up to 8 levels. Each end-of-interrupt write pops one level. An end-of-interrupt write on an empty stack has no effect.
- R11: Read data appears on `reg_rdata` in the cycle after the access. Write-only and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| src_in | input | 32 | Interrupt source inputs, already synchronous to clk |
| irq_out | output | 1 | Interrupt request to the core |

## Verification
The assertions assume that `src_in` is already synchronous to `clk` and stays low while reset is held. They also assume that an edge on a source never lands in the same cycle as a clear or vector read aimed at that source; if it did, the new edge would win. The stimulus changes inputs only on falling clock edges and issues one register access at a time. Every edge-latch clear is placed at least one cycle away from an edge on the same source. Priorities are nested in rising order, so the stack is never pushed past its depth.

// File: rtl/vic_pkg.sv
package vic_pkg;
   typedef enum logic [1:0] {
      TRIG_HIGH = 2'b00,
      TRIG_RISE = 2'b01,
      TRIG_LOW  = 2'b10,
      TRIG_FALL = 2'b11
   } trig_e;

   localparam logic [7:0] MAP_MODE_BASE = 8'h00;
   localparam logic [7:0] MAP_VEC_BASE  = 8'h40;
   localparam logic [7:0] MAP_IVR       = 8'h80;
   localparam logic [7:0] MAP_SPU       = 8'h81;
   localparam logic [7:0] MAP_EN        = 8'h82;
   localparam logic [7:0] MAP_DIS       = 8'h83;
   localparam logic [7:0] MAP_CLR       = 8'h84;
   localparam logic [7:0] MAP_EOI       = 8'h85;
   localparam int unsigned MAP_SLOT_W   = 6;
endpackage

// File: rtl/vic_src.sv
module vic_src
   import vic_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  src_i,
   input  trig_e trig_i,
   input  logic  clr_i,
   input  logic  ack_i,
   output logic  pend_o
);
   logic prev_q;
   logic latch_q;
   logic is_edge;
   logic inv;
   logic edge_seen;

   assign is_edge   = trig_i[0];
   assign inv       = trig_i[1];
   assign edge_seen = inv ? (prev_q & ~src_i) : (src_i & ~prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q <= src_i;
         if (!is_edge) begin
            latch_q <= 1'b0;
         end else if (edge_seen) begin
            latch_q <= 1'b1;
         end else if (clr_i || ack_i) begin
            latch_q <= 1'b0;
         end
      end
   end

   assign pend_o = is_edge ? latch_q : (src_i ^ inv);

   // R6: a clear or acknowledge with no fresh edge empties the latch
   p_edge_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i || ack_i) && !(is_edge && edge_seen)) |=> !latch_q);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned PRIO_W  = 3,
   localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]             cand_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   output logic                           valid_o,
   output logic [IDX_W-1:0]               idx_o,
   output logic [PRIO_W-1:0]              prio_o
);
   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      prio_o  = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (cand_i[i] && (!valid_o || prio_i[i] >= prio_o)) begin
            valid_o = 1'b1;
            idx_o   = IDX_W'(i);
            prio_o  = prio_i[i];
         end
      end
   end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned PRIO_W = 3,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [PRIO_W-1:0] push_lvl_i,
   input  logic              pop_i,
   output logic [PRIO_W:0]   thr_o,
   output logic [CNT_W-1:0]  cnt_o
);
   logic [PRIO_W-1:0] stk_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic [PTR_W-1:0]  top_ptr;
   logic [PTR_W-1:0]  push_ptr;
   logic [PRIO_W-1:0] top_lvl;
   logic              empty;
   logic              full;

   assign empty    = (cnt_q == '0);
   assign full     = (cnt_q == CNT_W'(DEPTH));
   assign top_ptr  = PTR_W'(cnt_q - 1'b1);
   assign push_ptr = PTR_W'(cnt_q);
   assign top_lvl  = stk_q[top_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
      end else if (push_i && !full) begin
         stk_q[push_ptr] <= push_lvl_i;
         cnt_q           <= cnt_q + 1'b1;
      end else if (pop_i && !empty) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign thr_o = empty ? '0 : ({1'b0, top_lvl} + 1'b1);
   assign cnt_o = cnt_q;

   // R10: the stack never receives a push while full
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full);
   // R8: every push sits strictly above the current top
   p_push_above_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !empty) |-> (push_lvl_i > top_lvl));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 32,
   parameter int unsigned PRIO_W     = 3,
   parameter int unsigned NEST_DEPTH = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned FAST_SRC   = 0,
   parameter int unsigned EXT_FIRST  = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_SRC-1:0] src_in,
   output logic              irq_out
);
   localparam int unsigned IDX_W  = $clog2(NUM_SRC);
   localparam int unsigned CNT_W  = $clog2(NEST_DEPTH + 1);
   localparam int unsigned SLOT_W = MAP_SLOT_W;

   function automatic logic [NUM_SRC-1:0] trig_ok_mask();
      logic [NUM_SRC-1:0] m;
      for (int i = 0; i < NUM_SRC; i++)
         m[i] = (i == FAST_SRC) || (i >= EXT_FIRST);
      return m;
   endfunction
   localparam logic [NUM_SRC-1:0] TRIG_OK = trig_ok_mask();

   if (NUM_SRC < 2 || NUM_SRC > (1 << (SLOT_W - 1)) || NUM_SRC > DATA_W) begin : g_bad_num
      $error("vec_irq_ctrl: NUM_SRC out of range");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio
      $error("vec_irq_ctrl: PRIO_W must be 1..4");
   end
   if (NEST_DEPTH < (1 << PRIO_W)) begin : g_bad_depth
      $error("vec_irq_ctrl: NEST_DEPTH must cover every priority level");
   end
   if (ADDR_W != 8 || DATA_W < 8) begin : g_bad_bus
      $error("vec_irq_ctrl: ADDR_W must be 8 and DATA_W at least 8");
   end

   // ---- access decode ----
   logic wr, rd;
   logic mode_hit, vec_hit;
   logic [IDX_W-1:0] slot;
   assign wr   = reg_valid &  reg_write;
   assign rd   = reg_valid & ~reg_write;
   assign slot = reg_addr[IDX_W-1:0];
   assign mode_hit = (reg_addr[ADDR_W-1:SLOT_W] == MAP_MODE_BASE[ADDR_W-1:SLOT_W]) &&
                     (reg_addr[SLOT_W-1:0] < SLOT_W'(NUM_SRC));
   assign vec_hit  = (reg_addr[ADDR_W-1:SLOT_W] == MAP_VEC_BASE[ADDR_W-1:SLOT_W]) &&
                     (reg_addr[SLOT_W-1:0] < SLOT_W'(NUM_SRC));

   logic mode_wr, vec_wr, spu_wr, en_wr, dis_wr, clr_wr, eoi_wr, ivr_rd;
   assign mode_wr = wr && mode_hit;
   assign vec_wr  = wr && vec_hit;
   assign spu_wr  = wr && (reg_addr == MAP_SPU);
   assign en_wr   = wr && (reg_addr == MAP_EN);
   assign dis_wr  = wr && (reg_addr == MAP_DIS);
   assign clr_wr  = wr && (reg_addr == MAP_CLR);
   assign eoi_wr  = wr && (reg_addr == MAP_EOI);
   assign ivr_rd  = rd && (reg_addr == MAP_IVR);

   // ---- configuration state ----
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
   logic [NUM_SRC-1:0][1:0]        trig_w;
   logic [DATA_W-1:0]              vec_q [NUM_SRC];
   logic [DATA_W-1:0]              spu_q;
   logic [NUM_SRC-1:0]             en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= '0;
         spu_q  <= '0;
         en_q   <= '0;
         for (int i = 0; i < NUM_SRC; i++) vec_q[i] <= '0;
      end else begin
         if (mode_wr) prio_q[slot] <= reg_wdata[PRIO_W-1:0];
         if (vec_wr)  vec_q[slot]  <= reg_wdata;
         if (spu_wr)  spu_q        <= reg_wdata;
         if (en_wr)   en_q <= en_q | reg_wdata[NUM_SRC-1:0];
         else if (dis_wr) en_q <= en_q & ~reg_wdata[NUM_SRC-1:0];
      end
   end

   // ---- per-source trigger and pending ----
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] ack;
   logic [NUM_SRC-1:0] clr_vec;
   assign clr_vec = clr_wr ? reg_wdata[NUM_SRC-1:0] : '0;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      if (TRIG_OK[g]) begin : g_prog
         logic [1:0] t_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) t_q <= TRIG_HIGH;
            else if (mode_wr && slot == IDX_W'(g)) t_q <= reg_wdata[5:4];
         end
         assign trig_w[g] = t_q;
      end else begin : g_fixed
         assign trig_w[g] = TRIG_HIGH;
      end

      vic_src u_src (
         .clk    (clk),
         .rst_n  (rst_n),
         .src_i  (src_in[g]),
         .trig_i (trig_e'(trig_w[g])),
         .clr_i  (clr_vec[g]),
         .ack_i  (ack[g]),
         .pend_o (pend[g])
      );
   end

   // ---- selection ----
   logic              sel_valid;
   logic [IDX_W-1:0]  sel_idx;
   logic [PRIO_W-1:0] sel_prio;
   logic [PRIO_W:0]   thr;
   logic [CNT_W-1:0]  lvl_cnt;
   logic              qualify;
   logic              take;

   vic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .cand_i  (pend & en_q),
      .prio_i  (prio_q),
      .valid_o (sel_valid),
      .idx_o   (sel_idx),
      .prio_o  (sel_prio)
   );

   assign qualify = sel_valid && ({1'b0, sel_prio} >= thr);
   assign take    = ivr_rd && qualify;
   assign irq_out = qualify;

   always_comb begin
      ack = '0;
      ack[sel_idx] = take;
   end

   vic_nest_stack #(.DEPTH(NEST_DEPTH), .PRIO_W(PRIO_W)) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (take),
      .push_lvl_i (sel_prio),
      .pop_i      (eoi_wr),
      .thr_o      (thr),
      .cnt_o      (lvl_cnt)
   );

   // ---- read path ----
   logic [DATA_W-1:0] mode_word;
   logic [DATA_W-1:0] rd_val;
   always_comb begin
      mode_word = '0;
      mode_word[PRIO_W-1:0] = prio_q[slot];
      mode_word[5:4]        = trig_w[slot];
      rd_val = '0;
      if (mode_hit)               rd_val = mode_word;
      else if (vec_hit)           rd_val = vec_q[slot];
      else if (reg_addr == MAP_SPU) rd_val = spu_q;
      else if (reg_addr == MAP_IVR) rd_val = qualify ? vec_q[sel_idx] : spu_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  reg_rdata <= '0;
      else if (rd) reg_rdata <= rd_val;
   end

   // R10: a vector read with the request high adds one level
   p_push_on_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ivr_rd && irq_out) |=> (lvl_cnt == CNT_W'($past(lvl_cnt) + 1'b1)));
   // R9: a vector read with the request low gives the spurious vector, stack held
   p_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ivr_rd && !irq_out) |=> ((reg_rdata == $past(spu_q)) && $stable(lvl_cnt)));
   // R10: end-of-interrupt on a non-empty stack drops one level
   p_eoi_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && lvl_cnt != '0) |=> (lvl_cnt == CNT_W'($past(lvl_cnt) - 1'b1)));
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_VEC = 8'h40, A_IVR = 8'h80, A_SPU = 8'h81,
                          A_EN = 8'h82, A_DIS = 8'h83, A_CLR = 8'h84, A_EOI = 8'h85;
   localparam logic [31:0] SPV = 32'hDEAD_0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_valid, reg_write;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [31:0] src_in;
   logic        irq_out;

   int checks = 0, failures = 0;
   bit done = 0;
   logic mon_go = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .src_in(src_in), .irq_out(irq_out)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 0; reg_write = 0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      reg_valid = 1; reg_write = 0; reg_addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      reg_valid = 0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      @(negedge clk);
      check(irq_out === e, tag, {31'b0, irq_out}, {31'b0, e});
   endtask

   task automatic set_src(input int idx, input logic v);
      @(negedge clk);
      src_in[idx] = v;
   endtask

   // monitor: compares each read result against the scoreboard queue
   always @(posedge clk) mon_go <= rst_n && reg_valid && !reg_write;
   always @(negedge clk) begin
      if (mon_go) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R11 unexpected read", reg_rdata, 32'h0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(reg_rdata === e, t, reg_rdata, e);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 0; reg_valid = 0; reg_write = 0; reg_addr = '0; reg_wdata = '0; src_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      chk_irq(1'b0, "R1 irq after reset");
      rd(8'h05, 32'h0, "R1 mode reads zero");
      rd(A_VEC + 8'd3, 32'h0, "R1 vector reads zero");
      rd(A_SPU, 32'h0, "R1 spurious reads zero");
      rd(A_IVR, 32'h0, "R9 idle read gives spurious (zero)");
      rd(A_EN, 32'h0, "R11 write-only reads zero");

      wr(A_SPU, SPV);
      for (int i = 0; i < 32; i++) wr(A_VEC + 8'(i), 32'h100 + i);
      rd(A_VEC + 8'd7, 32'h107, "R3 vector readback");
      rd(A_SPU, SPV, "R3 spurious readback");

      // R3 / R4 mode layout and trigger lock
      wr(8'h00, 32'h15); rd(8'h00, 32'h15, "R3 mode src0 rising p5");
      wr(8'h1A, 32'hFFFF_FF33); rd(8'h1A, 32'h33, "R3 mode src26 falling p3");
      wr(8'h04, 32'h36); rd(8'h04, 32'h06, "R4 internal trigger fixed");

      // R2 / R5 enable, disable, level
      set_src(4, 1);
      chk_irq(1'b0, "R2 disabled source silent");
      wr(A_EN, 32'h10);  chk_irq(1'b1, "R2 enable");
      wr(A_EN, 32'h0);   chk_irq(1'b1, "R2 zero enable bits no effect");
      wr(A_DIS, 32'h0);  chk_irq(1'b1, "R2 zero disable bits no effect");
      wr(A_DIS, 32'h10); chk_irq(1'b0, "R2 disable");
      wr(A_EN, 32'h10);  chk_irq(1'b1, "R2 re-enable");

      // R7 / R8 / R9 / R10 single nest
      rd(A_IVR, 32'h104, "R7 vector of source 4");
      chk_irq(1'b0, "R8 equal priority masked by stack");
      rd(A_IVR, SPV, "R9 spurious while masked");
      wr(A_EOI, 0); chk_irq(1'b1, "R10 pop restores request");
      wr(A_EOI, 0); chk_irq(1'b1, "R10 pop on empty ignored");
      rd(A_IVR, 32'h104, "R10 stack empty after extra pop");
      wr(A_EOI, 0);
      set_src(4, 0); chk_irq(1'b0, "R5 high level follows input");

      // R4 / R5 low level on external source
      wr(8'h19, 32'h22); rd(8'h19, 32'h22, "R4 external trigger writable");
      wr(A_EN, 32'h0200_0000); chk_irq(1'b1, "R5 low level pending at 0");
      rd(A_IVR, 32'h119, "R7 vector of source 25");
      wr(A_EOI, 0);
      set_src(25, 1); chk_irq(1'b0, "R5 low level released at 1");
      wr(A_DIS, 32'h0200_0000);

      // R6 rising edge on source 0
      wr(A_EN, 32'h1);
      set_src(0, 1); chk_irq(1'b1, "R6 rising edge latched");
      set_src(0, 0); chk_irq(1'b1, "R6 latch holds after input falls");
      wr(A_CLR, 32'h1); chk_irq(1'b0, "R6 clear command empties latch");
      set_src(0, 1); chk_irq(1'b1, "R6 second rising edge");
      rd(A_IVR, 32'h100, "R7 vector of source 0");
      wr(A_EOI, 0); chk_irq(1'b0, "R6 vector read empties latch");
      set_src(0, 0);

      // R6 falling edge on source 26
      wr(A_EN, 32'h0400_0000);
      set_src(26, 1); chk_irq(1'b0, "R6 rising ignored by falling trigger");
      set_src(26, 0); chk_irq(1'b1, "R6 falling edge latched");
      rd(A_IVR, 32'h11A, "R7 vector of source 26");
      wr(A_EOI, 0); chk_irq(1'b0, "R6 falling latch cleared by read");

      // R7 tie and priority
      wr(8'h01, 32'h3); wr(8'h02, 32'h3); wr(8'h03, 32'h1);
      @(negedge clk); src_in[3:1] = 3'b111;
      wr(A_EN, 32'hE);
      rd(A_IVR, 32'h101, "R7 tie goes to lowest index");
      chk_irq(1'b0, "R8 lower or equal priorities masked");
      wr(A_EOI, 0);
      wr(8'h02, 32'h4);
      rd(A_IVR, 32'h102, "R7 higher priority wins");
      wr(A_EOI, 0);
      wr(A_DIS, 32'hE);
      @(negedge clk); src_in[3:1] = 3'b000;

      // R10 eight-deep nesting
      for (int k = 0; k < 8; k++) wr(8'(8 + k), 32'(k));
      @(negedge clk); src_in[15:8] = 8'hFF;
      for (int k = 0; k < 8; k++) begin
         wr(A_EN, 32'h1 << (8 + k));
         rd(A_IVR, 32'h108 + k, "R10 nested push");
      end
      rd(A_IVR, SPV, "R9 spurious at full depth");
      chk_irq(1'b0, "R8 request low at top level 7");
      for (int k = 0; k < 7; k++) wr(A_EOI, 0);
      chk_irq(1'b1, "R8 request back after seven pops");
      wr(A_EOI, 0);
      rd(A_IVR, 32'h10F, "R10 fully unwound");
      wr(A_EOI, 0); wr(A_EOI, 0);
      chk_irq(1'b1, "R10 pop on empty keeps state");

      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R11 all reads answered", 32'(exp_q.size()), 32'h0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule